// File: doc/BRIEF.md
# Selector Memory Serial Read-Back Scanner

This block gives a diagnostic path back out of the switch's selector memory. There are 69 selector slices: 68 data outputs and the activity-monitor selector. Each slice holds one committed 7-bit input identifier. A single serial-clock edge copies all 69 words at once into a 483-bit scan register. After that, one bit leaves on the serial data pin for each serial-clock edge while the scan control is held high.

The stream order is fixed. Slice 68 comes first and slice 0 comes last, and each word is sent from its most significant bit down. A host can therefore rebuild the whole selector table from 483 consecutive samples. After the last bit has been sent, the pin holds 0 until the next capture. All activity is gated by the serial-mode input. Nothing in this block writes the selector memory.

Top module: `scan_readback_top`

## Requirements
- R1: While reset is low, a clock edge clears the scan register and the bit count, so `sdout` is 0. Shift edges after reset with no capture keep `sdout` at 0.
- R2: A clock edge with `serial_mode`=1 and `scan_en`=0 captures all of `latch_words`, where slice s occupies bits [7s+6:7s]. Right after that edge, `sdout` shows bit 6 of slice 68 (bit 482).
- R3: Each clock edge with `serial_mode`=1 and `scan_en`=1 advances the stream by exactly one bit.
- R4: The slices leave in descending order: slice 68, then 67, and so on down to slice 0.
- R5: Within a slice, the bits leave from bit 6 down to bit 0.
- R6: Once all 483 captured bits have been presented, `sdout` stays 0 for every further shift edge until the next capture.
- R7: With `serial_mode`=0, clock edges neither capture nor shift, whatever `scan_en` and `latch_words` are doing. `sdout` holds its value.
- R8: A capture in the middle of a stream drops the rest of the old stream and restarts from bit 6 of slice 68 of the current `latch_words`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all actions occur on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| serial_mode | input | 1 | Serial-mode enable; gates both capture and shift |
| scan_en | input | 1 | 0 = capture on the next edge, 1 = shift on the next edge |
| latch_words | input | 483 | Committed selector words, slice s at bits [7s+6:7s] |
| sdout | output | 1 | Serial read-back data |

## Verification
The bench first loads slice-numbered words, where every slice holds its own index. Any swap of slices or any bit reversal inside a word then shows up at a distinct stream position. A second, scrambled word pattern is stopped partway through its stream by dropping serial mode while the words change. This shows that a held stream differs from a recapture. An all-ones pattern is then captured mid-stream. It separates a true restart, and the zero tail after bit 483, from leftover bits of the earlier pattern.

// File: rtl/scan_rb_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the selector-memory read-back scanner.
// Assumes the stream runs from the highest slice down, each word MSB first.
package scan_rb_pkg;
    localparam int SLICES_DEF = 69;
    localparam int WORD_W_DEF = 7;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } scan_op_e;

    // Register position of (slice, bit). The register is shifted out from its
    // top end, so stream index i = TOTAL-1-position.
    function automatic int reg_pos(input int slice, input int bit_i, input int word_w);
        return slice * word_w + bit_i;
    endfunction
endpackage

// File: rtl/scan_rb_decode.sv
`timescale 1ns/1ps
// Decodes the mode pins into one operation for each serial-clock edge.
// Assumes the mode pins are already stable with respect to clk.
module scan_rb_decode
    import scan_rb_pkg::*;
(
    input  logic     serial_mode,
    input  logic     scan_en,
    output scan_op_e op
);
    // Pick the operation: nothing happens outside serial mode.
    always_comb begin
        if (!serial_mode)  op = OP_IDLE;
        else if (scan_en)  op = OP_SHIFT;
        else               op = OP_LOAD;
    end
endmodule

// File: rtl/scan_rb_order.sv
`timescale 1ns/1ps
// Places each stored word bit at the register position that gives the
// stream order (top slice first, MSB first). Purely combinational.
module scan_rb_order
    import scan_rb_pkg::*;
#(
    parameter int SLICES = SLICES_DEF,
    parameter int WORD_W = WORD_W_DEF,
    localparam int TOTAL = SLICES * WORD_W
) (
    input  logic [TOTAL-1:0] words,
    output logic [TOTAL-1:0] load_vec
);
    for (genvar s = 0; s < SLICES; s++) begin : g_slice
        for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            // Route word bit b of slice s to its stream slot.
            assign load_vec[reg_pos(s, b, WORD_W)] = words[s*WORD_W + b];
        end
    end
endmodule

// File: rtl/scan_rb_shifter.sv
`timescale 1ns/1ps
// Scan register: parallel capture, shift toward the top, zero fill.
// Assumes op is decoded from pins that are synchronous to clk.
module scan_rb_shifter
    import scan_rb_pkg::*;
#(
    parameter int TOTAL = SLICES_DEF * WORD_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scan_op_e         op,
    input  logic [TOTAL-1:0] load_vec,
    output logic             head_bit
);
    logic [TOTAL-1:0] shreg;

    // Capture all slices at once, or move the stream on by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                shreg <= '0;
        else if (op == OP_LOAD)    shreg <= load_vec;
        else if (op == OP_SHIFT)   shreg <= {shreg[TOTAL-2:0], 1'b0};
    end

    assign head_bit = shreg[TOTAL-1];
endmodule

// File: rtl/scan_rb_count.sv
`timescale 1ns/1ps
// Counts the bits still to be presented; marks the stream live while nonzero.
// Assumes a capture always restarts the full count.
module scan_rb_count
    import scan_rb_pkg::*;
#(
    parameter int TOTAL = SLICES_DEF * WORD_W_DEF,
    localparam int CNT_W = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  scan_op_e         op,
    output logic [CNT_W-1:0] remaining,
    output logic             live
);
    // Reload on capture; count down on each shift until empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   remaining <= '0;
        else if (op == OP_LOAD)                       remaining <= CNT_W'(TOTAL);
        else if (op == OP_SHIFT && remaining != '0)   remaining <= remaining - 1'b1;
    end

    assign live = (remaining != '0);
endmodule

// File: rtl/scan_readback_top.sv
`timescale 1ns/1ps
// Selector-memory read-back scanner. Captures every slice word on one
// serial-clock edge, then presents them serially: top slice first, MSB
// first, and 0 after the last bit. Assumes all inputs are synchronous to clk.
module scan_readback_top
    import scan_rb_pkg::*;
#(
    parameter int SLICES = SLICES_DEF,
    parameter int WORD_W = WORD_W_DEF,
    localparam int TOTAL = SLICES * WORD_W,
    localparam int CNT_W = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             serial_mode,
    input  logic             scan_en,
    input  logic [TOTAL-1:0] latch_words,
    output logic             sdout
);
    scan_op_e         op;
    logic [TOTAL-1:0] load_vec;
    logic             head_bit;
    logic [CNT_W-1:0] remaining;
    logic             live;

    scan_rb_decode dec_i (
        .serial_mode (serial_mode),
        .scan_en     (scan_en),
        .op          (op)
    );

    scan_rb_order #(.SLICES(SLICES), .WORD_W(WORD_W)) ord_i (
        .words    (latch_words),
        .load_vec (load_vec)
    );

    scan_rb_shifter #(.TOTAL(TOTAL)) shf_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .load_vec (load_vec),
        .head_bit (head_bit)
    );

    scan_rb_count #(.TOTAL(TOTAL)) cnt_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .remaining (remaining),
        .live      (live)
    );

    // Present the head bit only while captured bits remain.
    assign sdout = head_bit & live;
endmodule

// File: rtl/scan_readback_chk.sv
`timescale 1ns/1ps
// Property checker for scan_readback_top, attached with bind below.
module scan_readback_chk #(
    parameter int TOTAL = 483,
    localparam int CNT_W = $clog2(TOTAL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             serial_mode,
    input logic             scan_en,
    input logic             top_bit,
    input logic [CNT_W-1:0] remaining,
    input logic             sdout
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sdout == 1'b0 && remaining == '0));

    // R2
    load_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && !scan_en) |=> (sdout == $past(top_bit) && remaining == CNT_W'(TOTAL)));

    // R3
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_mode && scan_en && remaining != '0) |=> (remaining == $past(remaining) - 1'b1));

    // R6
    drained_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (remaining == '0) |-> (sdout == 1'b0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !serial_mode |=> ($stable(sdout) && $stable(remaining)));
endmodule

bind scan_readback_top scan_readback_chk #(.TOTAL(TOTAL)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .serial_mode (serial_mode),
    .scan_en     (scan_en),
    .top_bit     (latch_words[TOTAL-1]),
    .remaining   (remaining),
    .sdout       (sdout)
);

// File: tb/scan_readback_top_tb_top.sv
`timescale 1ns/1ps
module scan_readback_top_tb_top;
    localparam int SL = 69;
    localparam int W  = 7;
    localparam int N  = SL * W;

    typedef struct {
        logic exp;
        int   req;
    } exp_item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         serial_mode = 1'b0;
    logic         scan_en = 1'b0;
    logic [N-1:0] latch_words = '0;
    logic         sdout;

    logic [W-1:0] words [SL];
    logic         stream [N];
    exp_item_t    sb_q [$];
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #2.5 clk = ~clk;

    scan_readback_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .serial_mode (serial_mode),
        .scan_en     (scan_en),
        .latch_words (latch_words),
        .sdout       (sdout)
    );

    // Pack the word table onto the port and build the expected stream:
    // slice 68 first, MSB first inside each slice (R4, R5).
    task automatic apply_words();
        for (int s = 0; s < SL; s++) latch_words[s*W +: W] = words[s];
        for (int s = SL - 1; s >= 0; s--)
            for (int b = W - 1; b >= 0; b--)
                stream[(SL-1-s)*W + (W-1-b)] = words[s][b];
    endtask

    // Driver: set the inputs for the next edge and queue the expected sdout.
    task automatic cyc(input logic ser, input logic scn, input logic e, input int req);
        @(negedge clk);
        serial_mode = ser;
        scan_en = scn;
        sb_q.push_back('{exp: e, req: req});
    endtask

    // Stream requirement tag: slice boundaries test R4, the bits inside a slice test R5.
    function automatic int tag_of(input int k);
        return (k % W == 0) ? 4 : 5;
    endfunction

    // Monitor: compare sdout shortly after each edge against the queued item.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_item_t it;
            it = sb_q.pop_front();
            n_run++;
            if (sdout !== it.exp) begin
                n_fail++;
                $display("FAIL R%0d: sdout=%b expected %b at %0t", it.req, sdout, it.exp, $time);
            end
        end
    end

    initial begin : watchdog
        #1000000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic held;
        // R1: reset clears; shifting without a capture gives 0.
        cyc(1, 0, 1'b0, 1);
        cyc(1, 1, 1'b0, 1);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1, 1, 1'b0, 1);

        // Pattern A: each slice holds its own index.
        for (int s = 0; s < SL; s++) words[s] = W'(s);
        apply_words();
        cyc(1, 0, stream[0], 2);                       // R2 capture and head bit
        for (int k = 1; k < N; k++) cyc(1, 1, stream[k], tag_of(k)); // R3 one bit per edge
        for (int i = 0; i < 4; i++) cyc(1, 1, 1'b0, 6); // R6 zero tail

        // Pattern B: scrambled words, paused by serial mode low.
        for (int s = 0; s < SL; s++) words[s] = W'((s * 37 + 11) ^ (s >> 1));
        apply_words();
        cyc(1, 0, stream[0], 2);
        for (int k = 1; k <= 100; k++) cyc(1, 1, stream[k], 3);
        held = stream[100];
        for (int s = 0; s < SL; s++) words[s] = 7'h7F;
        for (int s = 0; s < SL; s++) latch_words[s*W +: W] = words[s];
        cyc(0, 1, held, 7);                            // R7 no shift
        cyc(0, 0, held, 7);                            // R7 no capture
        cyc(0, 1, held, 7);
        cyc(0, 0, held, 7);
        // Restore B's words; the stream goes on from bit 101.
        for (int s = 0; s < SL; s++) words[s] = W'((s * 37 + 11) ^ (s >> 1));
        apply_words();
        for (int k = 101; k < 200; k++) cyc(1, 1, stream[k], 3);

        // Pattern C: all ones captured mid-stream (R8).
        for (int s = 0; s < SL; s++) words[s] = 7'h7F;
        apply_words();
        cyc(1, 0, 1'b1, 8);
        for (int k = 1; k < N; k++) cyc(1, 1, stream[k], 8);
        for (int i = 0; i < 3; i++) cyc(1, 1, 1'b0, 6);  // R6 after a full stream
        cyc(0, 1, 1'b0, 7);

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule